// File: doc/BRIEF.md
# Up/Down Interval Timer with Shadowed Reload

This block is a free-running interval timer. It counts up from zero to a programmable
reload value, or down from that value to zero, advancing once per prescaler tick. Each
pass through the end of the range is a wrap. A repetition counter decides which wraps
raise an update event. An update event copies the buffered reload, prescaler and
repetition settings into the working copies, pulses a strobe output and sets a sticky
interrupt flag.

Software programs the block through a small write port with four targets: control,
reload, prescaler and repetition. Control bit 0 enables counting. Control bit 1 selects
the direction (1 = down). Control bit 2 selects buffered reload (1 = new reload values
wait for the next update event). Control bit 3 blocks update events. A separate request
input forces an update at once. A clear input drops the interrupt flag.

The counter is driven by a small state machine with three states. ST_HALT holds the count
frozen. ST_UP counts upward. ST_DOWN counts downward. The transitions are taken on the
clock edge after the control register changes:
- any state goes to ST_HALT when the enable bit is 0;
- any state goes to ST_UP when the enable bit is 1 and the direction bit is 0;
- any state goes to ST_DOWN when the enable bit is 1 and the direction bit is 1.

Top module: `updn_timer`

## Requirements
- R1: In ST_UP each prescaler tick adds one to the count. On a tick where the count is equal to or above the working reload value, the count goes to 0 instead, and that tick is a wrap.
- R2: In ST_DOWN each tick subtracts one from the count. On a tick where the count is 0, the count loads the working reload value instead, and that tick is a wrap.
- R3: With a working prescaler setting P, ticks come every P+1 enabled cycles. A prescaler value written through the port (`wr_sel` = 2) takes effect only at the next update event.
- R4: With control bit 2 clear, a reload value written through the port (`wr_sel` = 1) is used on the next tick. In up mode the count then wraps at the new value.
- R5: With control bit 2 set, a reload write only fills the buffer. The count still runs to the old value, and the new value becomes active at the next update event.
- R6: With a repetition setting N (`wr_sel` = 3, loaded at an update event), one update event occurs every N+1 wraps. With N = 0, every wrap is an update event.
- R7: A one-cycle pulse on `sw_upd_req` produces an update event on the next edge and sets the count. In up mode the count goes to 0; in down mode it goes to the buffered reload value. It also restarts the prescaler and reloads the repetition counter.
- R8: While control bit 3 is set, there are no update events, no strobe and no flag. The working registers are not reloaded, and `sw_upd_req` is ignored.
- R9: `irq_flag` is set on every update event. It stays set until `irq_clr` is pulsed, and a set in the same cycle as a clear wins.
- R10: With control bit 0 clear, the block enters ST_HALT one edge later and the count holds its value. The count is not reset.
- R11: After reset, the count is 0, the strobe and the flag are low, all control bits are 0, the reload value is all ones (0xFFFF), and the prescaler and repetition settings are 0.
- R12: With a reload value of 0, the count stays at 0 and every tick is an update event.
- R13: `upd_evt` is high for exactly the cycle after the edge that applied the update. That edge is the one where the count took its wrapped or reinitialised value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 reload, 2 prescaler, 3 repetition |
| wr_data | input | CNT_W | Write data; the prescaler uses the low PSC_W bits and the repetition setting uses the low REP_W bits |
| sw_upd_req | input | 1 | Software request for an immediate update event |
| irq_clr | input | 1 | Clears the interrupt flag |
| count | output | CNT_W | Current counter value |
| upd_evt | output | 1 | One-cycle update event strobe |
| irq_flag | output | 1 | Sticky update interrupt flag |

## Verification
The bench sweeps both directions against several prescaler, reload and repetition settings, including reload 0. It predicts every cycle's count and strobe arithmetically from the time since a software update, so an off-by-one in the wrap compare or in the prescaler period shows up as a drifting count, and a wrong repetition reload shows up as a misplaced strobe. Mid-run reload writes are checked with buffering on and off: a design that ignores the buffer bit wraps early at the new value, or wraps late at the old one. A mid-period prescaler write and a period with updates blocked expose designs that apply settings outside update events, raise the flag while updates are blocked, or let a blocked software request restart the count.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_PSC    = 2'd2,
        SEL_REP    = 2'd3
    } wr_sel_e;

    // bit 3 .. bit 0
    typedef struct packed {
        logic upd_block;
        logic buffered;
        logic down;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = 4;

endpackage

// File: rtl/updn_timer_regs.sv
module updn_timer_regs
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             upd_fire,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload_buf,
    output logic [CNT_W-1:0] reload_act,
    output logic [PSC_W-1:0] psc_buf,
    output logic [REP_W-1:0] rep_buf
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_buf_q;
    logic [CNT_W-1:0] reload_act_q;
    logic [PSC_W-1:0] psc_buf_q;
    logic [REP_W-1:0] rep_buf_q;
    logic             wr_ctrl, wr_reload, wr_psc, wr_rep;

    always_comb begin
        wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
        wr_reload = wr_en && (wr_sel == SEL_RELOAD);
        wr_psc    = wr_en && (wr_sel == SEL_PSC);
        wr_rep    = wr_en && (wr_sel == SEL_REP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            reload_buf_q <= '1;
            reload_act_q <= '1;
            psc_buf_q    <= '0;
            rep_buf_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            end
            if (wr_psc) begin
                psc_buf_q <= wr_data[PSC_W-1:0];
            end
            if (wr_rep) begin
                rep_buf_q <= wr_data[REP_W-1:0];
            end
            if (wr_reload) begin
                reload_buf_q <= wr_data;
            end
            if (upd_fire) begin
                reload_act_q <= reload_buf_q;
            end
            if (wr_reload && !ctrl_q.buffered) begin
                reload_act_q <= wr_data;
            end
        end
    end

    assign ctrl       = ctrl_q;
    assign reload_buf = reload_buf_q;
    assign reload_act = reload_act_q;
    assign psc_buf    = psc_buf_q;
    assign rep_buf    = rep_buf_q;

    // R5
    buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.buffered && !upd_fire) |=> $stable(reload_act_q));

    // R8
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.upd_block && ctrl_q.buffered) |=> $stable(reload_act_q));

endmodule

// File: rtl/updn_timer_presc.sv
module updn_timer_presc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             sw_fire,
    input  logic             upd_fire,
    input  logic [PSC_W-1:0] psc_buf,
    output logic             tick
);

    logic [PSC_W-1:0] pcnt_q;
    logic [PSC_W-1:0] psc_act_q;

    assign tick = running && (pcnt_q == psc_act_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q    <= '0;
            psc_act_q <= '0;
        end else begin
            if (sw_fire) begin
                pcnt_q <= '0;
            end else if (running) begin
                pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
            end
            if (upd_fire) begin
                psc_act_q <= psc_buf;
            end
        end
    end

    // R3
    psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= psc_act_q);

endmodule

// File: rtl/updn_timer_rep.sv
module updn_timer_rep #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             upd_fire,
    input  logic [REP_W-1:0] rep_buf,
    output logic             rep_zero
);

    logic [REP_W-1:0] rep_cnt_q;

    assign rep_zero = (rep_cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_cnt_q <= '0;
        end else if (upd_fire) begin
            rep_cnt_q <= rep_buf;
        end else if (wrap && !rep_zero) begin
            rep_cnt_q <= rep_cnt_q - 1'b1;
        end
    end

    // R6
    rep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_fire && !wrap) |=> $stable(rep_cnt_q));

endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             tick,
    input  logic             rep_zero,
    input  logic [CNT_W-1:0] reload_act,
    input  logic [CNT_W-1:0] reload_buf,
    input  logic             sw_req,
    output logic             running,
    output logic             wrap,
    output logic             sw_fire,
    output logic             upd_fire,
    output logic [CNT_W-1:0] count,
    output logic             upd_evt
);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             upd_evt_q;

    // next-state selection
    always_comb begin
        if (!ctrl.run) begin
            state_d = ST_HALT;
        end else if (ctrl.down) begin
            state_d = ST_DOWN;
        end else begin
            state_d = ST_UP;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    assign running = (state_q != ST_HALT);
    assign sw_fire = sw_req && !ctrl.upd_block;

    // per-state counter behaviour
    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                cnt_d = cnt_q;
            end
            ST_UP: begin
                if (tick) begin
                    if (cnt_q >= reload_act) begin
                        cnt_d = '0;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DOWN: begin
                if (tick) begin
                    if (cnt_q == '0) begin
                        cnt_d = reload_act;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                cnt_d = cnt_q;
            end
        endcase
        if (sw_fire) begin
            cnt_d = ctrl.down ? reload_buf : '0;
            wrap  = 1'b0;
        end
    end

    assign upd_fire = sw_fire || (wrap && rep_zero && !ctrl.upd_block);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            upd_evt_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            upd_evt_q <= upd_fire;
        end
    end

    assign count   = cnt_q;
    assign upd_evt = upd_evt_q;

    // R1
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && tick && !sw_fire && cnt_q < reload_act)
        |=> cnt_q == $past(cnt_q) + 1'b1);

    // R2
    down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && tick && !sw_fire && cnt_q == '0)
        |=> cnt_q == $past(reload_act));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !sw_fire) |=> $stable(cnt_q));

    // R12
    zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && tick && !sw_fire && reload_act == '0) |=> cnt_q == '0);

endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sw_upd_req,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             upd_evt,
    output logic             irq_flag
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_buf, reload_act;
    logic [PSC_W-1:0] psc_buf;
    logic [REP_W-1:0] rep_buf;
    logic             running, tick, wrap, rep_zero, sw_fire, upd_fire;
    logic             irq_q;

    updn_timer_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .upd_fire   (upd_fire),
        .ctrl       (ctrl),
        .reload_buf (reload_buf),
        .reload_act (reload_act),
        .psc_buf    (psc_buf),
        .rep_buf    (rep_buf)
    );

    updn_timer_presc #(.PSC_W(PSC_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .sw_fire  (sw_fire),
        .upd_fire (upd_fire),
        .psc_buf  (psc_buf),
        .tick     (tick)
    );

    updn_timer_rep #(.REP_W(REP_W)) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .upd_fire (upd_fire),
        .rep_buf  (rep_buf),
        .rep_zero (rep_zero)
    );

    updn_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .tick       (tick),
        .rep_zero   (rep_zero),
        .reload_act (reload_act),
        .reload_buf (reload_buf),
        .sw_req     (sw_upd_req),
        .running    (running),
        .wrap       (wrap),
        .sw_fire    (sw_fire),
        .upd_fire   (upd_fire),
        .count      (count),
        .upd_evt    (upd_evt)
    );

    // sticky flag: a set beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (upd_fire) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    assign irq_flag = irq_q;

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R13
    strobe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |-> irq_flag);

endmodule

// File: tb/updn_timer_tb.sv
`timescale 1ns/1ps
module updn_timer_tb;
    import updn_timer_pkg::*;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             sw_upd_req = 1'b0;
    logic             irq_clr = 1'b0;
    logic [CNT_W-1:0] count;
    logic             upd_evt;
    logic             irq_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    updn_timer #(.CNT_W(CNT_W), .PSC_W(16), .REP_W(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .sw_upd_req (sw_upd_req),
        .irq_clr    (irq_clr),
        .count      (count),
        .upd_evt    (upd_evt),
        .irq_flag   (irq_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [CNT_W-1:0] cv(input int run, input int dn, input int buf_en, input int blk);
        cv = '0;
        cv[0] = run[0];
        cv[1] = dn[0];
        cv[2] = buf_en[0];
        cv[3] = blk[0];
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [1:0] sel, input int data);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = data[CNT_W-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sw_pulse();
        sw_upd_req = 1'b1;
        @(negedge clk);
        sw_upd_req = 1'b0;
    endtask

    task automatic clr_pulse();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // R1 R2 R3 R6 R7 R12 R13 sweep
    task automatic run_cfg(input int dn, input int p, input int a, input int r);
        int nmax, t, exp_c, exp_u;
        string tag_c, tag_u;
        wr(SEL_CTRL, int'(cv(1, dn, 0, 0)));
        wr(SEL_PSC, p);
        wr(SEL_RELOAD, a);
        wr(SEL_REP, r);
        @(negedge clk);
        @(negedge clk);
        sw_pulse();
        chk("R7 count after software update", int'(count), dn ? a : 0);
        chk("R7 strobe after software update", int'(upd_evt), 1);
        tag_c = (a == 0) ? "R12 count" : (dn ? "R2 R3 count" : "R1 R3 count");
        tag_u = (a == 0) ? "R12 strobe" : ((r != 0) ? "R6 strobe" : "R13 strobe");
        nmax = (p + 1) * (a + 1) * (r + 1) * 2 + 3;
        for (int n = 1; n <= nmax; n++) begin
            @(negedge clk);
            t = n / (p + 1);
            exp_c = dn ? (a - (t % (a + 1))) : (t % (a + 1));
            exp_u = ((n % (p + 1)) == 0 && (t % (a + 1)) == 0
                     && ((t / (a + 1)) % (r + 1)) == 0) ? 1 : 0;
            chk(tag_c, int'(count), exp_c);
            chk(tag_u, int'(upd_evt), exp_u);
        end
        chk("R9 flag still set", int'(irq_flag), 1);
    endtask

    // R4 / R5 reload write mid-period
    task automatic reload_case(input int buffered);
        int pos, exp_c, exp_u;
        wr(SEL_CTRL, int'(cv(1, 0, 0, 0)));
        wr(SEL_PSC, 0);
        wr(SEL_REP, 0);
        wr(SEL_RELOAD, 10);
        wr(SEL_CTRL, int'(cv(1, 0, buffered, 0)));
        @(negedge clk);
        @(negedge clk);
        sw_pulse();
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk(buffered ? "R5 count before write" : "R4 count before write", int'(count), 5);
        wr(SEL_RELOAD, 8);
        chk(buffered ? "R5 count at write" : "R4 count at write", int'(count), 6);
        for (int m = 1; m <= 22; m++) begin
            @(negedge clk);
            pos = 6 + m;
            if (buffered != 0) begin
                exp_c = (pos <= 10) ? pos : ((pos - 11) % 9);
                exp_u = (pos >= 11 && ((pos - 11) % 9) == 0) ? 1 : 0;
                chk("R5 count", int'(count), exp_c);
                chk("R5 strobe", int'(upd_evt), exp_u);
            end else begin
                exp_c = (pos <= 8) ? pos : ((pos - 9) % 9);
                exp_u = (pos >= 9 && ((pos - 9) % 9) == 0) ? 1 : 0;
                chk("R4 count", int'(count), exp_c);
                chk("R4 strobe", int'(upd_evt), exp_u);
            end
        end
    endtask

    task automatic run_tests();
        int held, exp_c;
        // R11 reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 count", int'(count), 0);
        chk("R11 strobe", int'(upd_evt), 0);
        chk("R11 flag", int'(irq_flag), 0);

        // R11 default reload all ones, seen by a down-count from 0
        wr(SEL_CTRL, int'(cv(1, 1, 0, 0)));
        chk("R11 count after enable write", int'(count), 0);
        @(negedge clk);
        chk("R11 count while entering ST_DOWN", int'(count), 0);
        @(negedge clk);
        chk("R11 reload default", int'(count), 16'hFFFF);
        chk("R11 strobe on first wrap", int'(upd_evt), 1);
        @(negedge clk);
        chk("R2 count down", int'(count), 16'hFFFE);
        chk("R9 flag held", int'(irq_flag), 1);
        clr_pulse();
        chk("R9 flag cleared", int'(irq_flag), 0);
        @(negedge clk);
        chk("R9 flag stays clear", int'(irq_flag), 0);

        // sweep
        for (int dn = 0; dn < 2; dn++)
            for (int p = 0; p < 3; p++)
                for (int ai = 0; ai < 3; ai++)
                    for (int ri = 0; ri < 2; ri++)
                        run_cfg(dn, p, (ai == 0) ? 0 : ((ai == 1) ? 1 : 3), ri * 2);

        reload_case(0);
        reload_case(1);

        // R3 prescaler change applies at update only
        wr(SEL_CTRL, int'(cv(1, 0, 0, 0)));
        wr(SEL_PSC, 0);
        wr(SEL_REP, 0);
        wr(SEL_RELOAD, 3);
        @(negedge clk);
        @(negedge clk);
        sw_pulse();
        wr(SEL_PSC, 3);
        chk("R3 count after psc write", int'(count), 1);
        for (int n = 2; n <= 16; n++) begin
            @(negedge clk);
            exp_c = (n < 4) ? n : (((n - 4) / 4) % 4);
            chk("R3 count", int'(count), exp_c);
            chk("R3 strobe", int'(upd_evt), (n == 4) ? 1 : 0);
        end

        // R8 updates blocked
        wr(SEL_PSC, 0);
        wr(SEL_CTRL, int'(cv(1, 0, 1, 0)));
        @(negedge clk);
        @(negedge clk);
        sw_pulse();
        chk("R8 setup count", int'(count), 0);
        clr_pulse();
        wr(SEL_CTRL, int'(cv(1, 0, 1, 1)));
        wr(SEL_RELOAD, 1);
        chk("R8 count", int'(count), 3);
        for (int n = 4; n <= 14; n++) begin
            sw_upd_req = (n == 7);
            @(negedge clk);
            chk("R8 count ignores reload and request", int'(count), n % 4);
            chk("R8 no strobe", int'(upd_evt), 0);
        end
        sw_upd_req = 1'b0;
        chk("R8 no flag", int'(irq_flag), 0);

        // R10 freeze
        wr(SEL_CTRL, int'(cv(0, 0, 0, 0)));
        @(negedge clk);
        held = int'(count);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R10 count frozen", int'(count), held);
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                #(200000 * 5);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule